// File: doc/BRIEF.md
# Smart Card Answer-to-Reset Timeout Monitor

This block supervises the start of a smart card session. Once the card's reset line is released, the card must begin its answer-to-reset (ATR) with an initial character, called TS. The whole response must then finish within a bounded time. The monitor counts elementary time units (ETU) in two windows that follow one another, and both windows report through one timeout output.

The first window opens at reset release and closes at the first start-bit leading edge on the I/O line. It catches a card that never answers (a mute card). The second window opens at that same leading edge and closes when the character receiver reports the last ATR character. It catches a response that takes too long.

The timeout flag stays set until software clears it. A cause bit beside the flag tells which window expired first. The two limits are held in byte-wide registers. These registers are written through a small strobe, select and data port.

Top module: `atr_timeout_mon`

## Requirements
- R1: After reset, `tmo_flag` and `tmo_mute` are 0, and all limit bytes are 0.
- R2: A write (`lim_wr`=1) loads `lim_data` into the register picked by `lim_sel`: 0 is the ATR limit low byte, 1 is the ATR limit high byte, 2 is the 8-bit TS limit, and 3 writes nothing.
- R3: A start-bit leading edge is a 1-to-0 transition of `io_line` after a two-flop synchroniser. No edge is seen while the line stays at one level.
- R4: A `card_rst_rel` pulse clears the TS count and starts it. The count rises by one on each `etu_tick`. While `ts_chk_en`=1, the flag sets with `tmo_mute`=1 on the tick that makes the count exceed the TS limit.
- R5: A leading edge that arrives before the TS limit is exceeded ends the TS window, and no TS timeout follows.
- R6: While `ts_chk_en`=0, the TS window never raises a timeout.
- R7: While `atr_rx_en`=1, the first leading edge starts the ATR count from zero, and later edges do not restart it. The flag sets with `tmo_mute`=0 on the tick that makes the count exceed the 16-bit ATR limit.
- R8: A `last_char` pulse that arrives before the ATR limit is exceeded ends the ATR window with no timeout.
- R9: Driving `atr_rx_en` low stops and clears the ATR window. After `atr_rx_en` is raised again, nothing is counted until a new leading edge arrives.
- R10: Once set, `tmo_flag` stays at 1 until a `tmo_clr` pulse. The clear returns both `tmo_flag` and `tmo_mute` to 0.
- R11: `tmo_mute` records the window that expired first. A later expiry while the flag is set does not change it.
- R12: The counters saturate and never wrap, so a limit of 255 (TS) still times out after exactly 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per ETU |
| io_line | input | 1 | Card I/O line, asynchronous |
| card_rst_rel | input | 1 | One-cycle pulse when card reset is released |
| atr_rx_en | input | 1 | Arms the ATR window |
| ts_chk_en | input | 1 | Enables the TS limit check |
| last_char | input | 1 | One-cycle pulse: last ATR character seen |
| lim_wr | input | 1 | Limit register write strobe |
| lim_sel | input | 2 | Limit register select |
| lim_data | input | 8 | Limit write data |
| tmo_clr | input | 1 | One-cycle pulse that clears the flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_mute | output | 1 | Cause: 1 = no TS (mute card), 0 = ATR too long |

## Verification
The assertions take `etu_tick`, `card_rst_rel`, `last_char` and `tmo_clr` to be pulses of one cycle. They also take `io_line` to hold each level for several cycles, so that the synchroniser passes every edge through. The bench changes every input on the falling clock edge and keeps each pulse one cycle wide. It holds the I/O line low for four cycles, and it sends no ETU ticks while an edge is moving through the synchroniser. This makes the count at each expiry exact.

// File: rtl/atr_timeout_mon.sv
module atr_timeout_mon #(
  parameter int ATR_W  = 16,
  parameter int TS_W   = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              etu_tick,
  input  logic              io_line,
  input  logic              card_rst_rel,
  input  logic              atr_rx_en,
  input  logic              ts_chk_en,
  input  logic              last_char,
  input  logic              lim_wr,
  input  logic [1:0]        lim_sel,
  input  logic [BYTE_W-1:0] lim_data,
  input  logic              tmo_clr,
  output logic              tmo_flag,
  output logic              tmo_mute
);
  localparam int ATR_CW = ATR_W + 1;
  localparam int TS_CW  = TS_W + 1;
  localparam int HI_W   = ATR_W - BYTE_W;

  logic [ATR_W-1:0]  atr_lim;
  logic [TS_W-1:0]   ts_lim;
  logic              io_s1, io_s2, io_prev;
  logic              io_fall;
  logic              ts_run, atr_run, atr_done;
  logic [TS_CW-1:0]  ts_cnt, ts_nxt;
  logic [ATR_CW-1:0] atr_cnt, atr_nxt;
  logic              ts_exp, atr_exp, atr_start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      atr_lim <= '0;
      ts_lim  <= '0;
    end else if (lim_wr) begin
      case (lim_sel)
        2'd0: atr_lim[BYTE_W-1:0]     <= lim_data;
        2'd1: atr_lim[ATR_W-1:BYTE_W] <= lim_data[HI_W-1:0];
        2'd2: ts_lim                  <= lim_data[TS_W-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {io_s1, io_s2, io_prev} <= 3'b111;
    else        {io_s1, io_s2, io_prev} <= {io_line, io_s1, io_s2};

  assign io_fall = io_prev & ~io_s2;

  assign ts_nxt  = (&ts_cnt)  ? ts_cnt  : ts_cnt + 1'b1;
  assign atr_nxt = (&atr_cnt) ? atr_cnt : atr_cnt + 1'b1;

  assign ts_exp    = ts_run & ts_chk_en & etu_tick & ~io_fall &
                     (ts_nxt > {1'b0, ts_lim});
  assign atr_start = atr_rx_en & ~atr_run & ~atr_done & io_fall;
  assign atr_exp   = atr_run & etu_tick & ~last_char &
                     (atr_nxt > {1'b0, atr_lim});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ts_run <= 1'b0;
      ts_cnt <= '0;
    end else if (card_rst_rel) begin
      ts_run <= 1'b1;
      ts_cnt <= '0;
    end else if (ts_run && (io_fall || ts_exp)) begin
      ts_run <= 1'b0;
    end else if (ts_run && etu_tick) begin
      ts_cnt <= ts_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      atr_run  <= 1'b0;
      atr_done <= 1'b0;
      atr_cnt  <= '0;
    end else if (!atr_rx_en) begin
      atr_run  <= 1'b0;
      atr_done <= 1'b0;
      atr_cnt  <= '0;
    end else if (atr_start) begin
      atr_run <= 1'b1;
      atr_cnt <= '0;
    end else if (atr_run && (last_char || atr_exp)) begin
      atr_run  <= 1'b0;
      atr_done <= 1'b1;
    end else if (atr_run && etu_tick) begin
      atr_cnt <= atr_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      tmo_mute <= 1'b0;
    end else if (ts_exp || atr_exp) begin
      if (!tmo_flag) begin
        tmo_flag <= 1'b1;
        tmo_mute <= ts_exp;
      end
    end else if (tmo_clr) begin
      tmo_flag <= 1'b0;
      tmo_mute <= 1'b0;
    end

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !tmo_clr |=> tmo_flag);

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !tmo_clr |=> $stable(tmo_mute));

  // R6
  mute_needs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) && tmo_mute |-> $past(ts_chk_en));

  // R7
  long_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) && !tmo_mute |-> $past(atr_rx_en));

  // R12
  ts_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&ts_cnt) && !card_rst_rel |=> (&ts_cnt));

  // R9
  atr_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !atr_rx_en |=> !atr_run && atr_cnt == '0);
endmodule

// File: tb/atr_timeout_mon_tb.sv
module atr_timeout_mon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic etu_tick = 1'b0, io_line = 1'b1, card_rst_rel = 1'b0;
  logic atr_rx_en = 1'b0, ts_chk_en = 1'b0, last_char = 1'b0;
  logic lim_wr = 1'b0, tmo_clr = 1'b0;
  logic [1:0] lim_sel = 2'd0;
  logic [7:0] lim_data = 8'd0;
  logic tmo_flag, tmo_mute;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  atr_timeout_mon u_dut (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_line(io_line),
    .card_rst_rel(card_rst_rel), .atr_rx_en(atr_rx_en), .ts_chk_en(ts_chk_en),
    .last_char(last_char), .lim_wr(lim_wr), .lim_sel(lim_sel),
    .lim_data(lim_data), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
    .tmo_mute(tmo_mute));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); etu_tick = 1'b1; end
    @(negedge clk); etu_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); lim_wr = 1'b1; lim_sel = sel; lim_data = d;
    @(negedge clk); lim_wr = 1'b0;
  endtask

  task automatic release_rst();
    @(negedge clk); card_rst_rel = 1'b1;
    @(negedge clk); card_rst_rel = 1'b0;
  endtask

  task automatic edge_io();
    @(negedge clk); io_line = 1'b0;
    repeat (4) @(negedge clk);
    io_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); tmo_clr = 1'b1;
    @(negedge clk); tmo_clr = 1'b0;
  endtask

  task automatic idle();
    atr_rx_en = 1'b0; ts_chk_en = 1'b0;
    clear_flag();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 flag", tmo_flag, 1'b0);
    check("R1 mute", tmo_mute, 1'b0);
    ts_chk_en = 1'b1;
    release_rst();
    ticks(1);
    check("R1 ts limit zero", tmo_flag, 1'b1);
    idle();
  endtask

  task automatic t_ts_timeout();
    wr(2'd2, 8'd5);
    wr(2'd3, 8'd1);
    ts_chk_en = 1'b1;
    release_rst();
    ticks(5);
    check("R4 before limit", tmo_flag, 1'b0);
    ticks(1);
    check("R4 at limit+1", tmo_flag, 1'b1);
    check("R4 cause", tmo_mute, 1'b1);
    repeat (5) @(negedge clk);
    check("R10 sticky", tmo_flag, 1'b1);
    clear_flag();
    check("R10 clear flag", tmo_flag, 1'b0);
    check("R10 clear mute", tmo_mute, 1'b0);
    idle();
  endtask

  task automatic t_ts_arrives();
    ts_chk_en = 1'b1;
    release_rst();
    ticks(3);
    edge_io();
    ticks(10);
    check("R5 TS arrived", tmo_flag, 1'b0);
    idle();
  endtask

  task automatic t_no_edge_level();
    ts_chk_en = 1'b1;
    release_rst();
    ticks(3);
    @(negedge clk); io_line = 1'b1;
    repeat (4) @(negedge clk);
    ticks(3);
    check("R3 steady high is no edge", tmo_flag, 1'b1);
    idle();
  endtask

  task automatic t_ts_disabled();
    wr(2'd2, 8'd2);
    ts_chk_en = 1'b0;
    release_rst();
    ticks(10);
    check("R6 check off", tmo_flag, 1'b0);
    idle();
  endtask

  task automatic t_atr_timeout();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h01);
    atr_rx_en = 1'b1;
    edge_io();
    ticks(100);
    edge_io();
    ticks(159);
    check("R7 before limit", tmo_flag, 1'b0);
    ticks(1);
    check("R7 at limit+1 (R2 bytes)", tmo_flag, 1'b1);
    check("R7 cause", tmo_mute, 1'b0);
    idle();
  endtask

  task automatic t_atr_last();
    wr(2'd0, 8'd10);
    wr(2'd1, 8'd0);
    atr_rx_en = 1'b1;
    edge_io();
    ticks(5);
    @(negedge clk); last_char = 1'b1;
    @(negedge clk); last_char = 1'b0;
    ticks(20);
    check("R8 last char", tmo_flag, 1'b0);
    idle();
  endtask

  task automatic t_atr_disable();
    atr_rx_en = 1'b1;
    edge_io();
    ticks(8);
    @(negedge clk); atr_rx_en = 1'b0;
    @(negedge clk); atr_rx_en = 1'b1;
    ticks(20);
    check("R9 disarmed", tmo_flag, 1'b0);
    edge_io();
    ticks(10);
    check("R9 restart at limit", tmo_flag, 1'b0);
    ticks(1);
    check("R9 restart limit+1", tmo_flag, 1'b1);
    idle();
  endtask

  task automatic t_cause();
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd2);
    ts_chk_en = 1'b1;
    atr_rx_en = 1'b1;
    release_rst();
    ticks(4);
    check("R11 ts first", tmo_mute, 1'b1);
    edge_io();
    ticks(3);
    check("R11 flag held", tmo_flag, 1'b1);
    check("R11 cause kept", tmo_mute, 1'b1);
    clear_flag();
    check("R10 cleared", tmo_flag, 1'b0);
    idle();
  endtask

  task automatic t_sat();
    wr(2'd2, 8'd255);
    ts_chk_en = 1'b1;
    release_rst();
    ticks(255);
    check("R12 at 255", tmo_flag, 1'b0);
    ticks(1);
    check("R12 at 256", tmo_flag, 1'b1);
    idle();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ts_timeout();
    t_ts_arrives();
    t_no_edge_level();
    t_ts_disabled();
    t_atr_timeout();
    t_atr_last();
    t_atr_disable();
    t_cause();
    t_sat();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule